// File: doc/BRIEF.md
# I2C Channel Select Switch

This block is a bus slave on a two-wire serial bus. It holds one control register, with no sub-address, and uses that register to connect one of two downstream bus segments or to disconnect both. SCL and SDA are brought into the system clock domain through two-flop synchronisers. The block detects START and STOP on the synchronised lines, matches the fixed 7-bit address 1110000 and acknowledges each byte. It drives an open-drain pull-down request for SDA and two channel-enable outputs.

In a write, each byte that follows an acknowledged address is taken as the new control value. Only bits 2..0 are stored. The channel outputs change at the falling SCL edge that ends the acknowledge clock of that byte, so the new selection is in force before STOP. In a read, the block returns the stored value as one byte. The byte is `00000` followed by bits 2..0, sent MSB first. The block repeats this byte for as long as the master acknowledges it.

Top module: `i2c_chan_switch`

## Requirements
- R1: While reset is asserted and after it is released, the control register is 0, both channel enables are low and the block does not pull SDA low.
- R2: A byte after START whose upper seven bits equal 1110000 is acknowledged: SDA is pulled low for the whole high period of the ninth SCL pulse. This applies with R/W (bit 0) = 0 and with R/W = 1.
- R3: After an address that does not match, the block neither acknowledges nor pulls SDA low. It ignores all further bytes until the next START or STOP, and those bytes leave the channel selection unchanged.
- R4: In a write, the block stores bits 2..0 of each data byte and acknowledges the byte. Bits 7..3 have no effect on the channel selection. The block never pulls SDA low during the eight data bits of a write.
- R5: Channel decode uses the stored value {B2,B1,B0}. The value 100 enables only channel 0, and 101 enables only channel 1. Every other value enables neither channel. The two enables are never high together.
- R6: The channel enables take their new value after the acknowledge clock of the data byte and before STOP. They change only while the synchronised SCL is low.
- R7: Further data bytes in the same write transaction each overwrite the register and are each acknowledged.
- R8: In a read, after the address is acknowledged, the block sends the byte {00000,B2,B1,B0} MSB first. It changes SDA only while SCL is low.
- R9: When the master acknowledges a read byte, the block sends the same byte again. When the master does not acknowledge, the block releases SDA and ignores the bus until the next START or STOP.
- R10: A repeated START at any point restarts address reception. A START always leaves SDA released.
- R11: The SDA pull-down changes only while the synchronised SCL is low. An SDA change that reaches the synchroniser in the same clock as an SCL fall is treated as data, not as START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| sda_drive_low | output | 1 | 1 requests the open-drain pull-down of SDA |
| chan0_en | output | 1 | Connects downstream channel 0 |
| chan1_en | output | 1 | Connects downstream channel 1 |

## Verification
Two things can land in the same synchronised cycle: a falling SCL edge and a change of SDA. When the master changes SDA with no hold time, the block sees the SCL fall, which triggers its own SDA update and the channel commit, in the same cycle as the new data level. It must not read that pair as START or STOP. The bench provokes this with a zero-hold mode for a write transaction and a read transaction. It judges the outcome by the acknowledge levels, the read-back byte and the channel enables, which it compares every clock against its own model.

// File: rtl/i2c_chan_switch.sv
module i2c_chan_switch #(
  parameter logic [6:0] SLV_ADDR = 7'b1110000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_drive_low,
  output logic chan0_en,
  output logic chan1_en
);

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_WR, ST_RD, ST_IGN} state_t;

  logic [1:0] scl_ff, sda_ff;
  logic       scl_q, sda_q;
  state_t     state;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  logic       ack_ph, rw, nack, sda_oe;
  logic [2:0] ctrl;

  wire scl_s     = scl_ff[1];
  wire sda_s     = sda_ff[1];
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire [7:0] rd_byte = {5'b0, ctrl};
  wire active    = (state == ST_ADDR) || (state == ST_WR) || (state == ST_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_in};
      sda_ff <= {sda_ff[0], sda_in};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bitcnt <= 4'd0;
      shreg  <= 8'd0;
      ack_ph <= 1'b0;
      rw     <= 1'b0;
      nack   <= 1'b0;
      sda_oe <= 1'b0;
      ctrl   <= 3'd0;
    end else if (start_det) begin
      state  <= ST_ADDR;
      bitcnt <= 4'd0;
      ack_ph <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      ack_ph <= 1'b0;
      sda_oe <= 1'b0;
    end else if (active) begin
      if (scl_rise) begin
        if (!ack_ph) begin
          shreg  <= {shreg[6:0], sda_s};
          bitcnt <= bitcnt + 4'd1;
        end else begin
          nack <= sda_s;
        end
      end else if (scl_fall) begin
        if (!ack_ph && bitcnt == 4'd8) begin
          ack_ph <= 1'b1;
          case (state)
            ST_ADDR: begin
              if (shreg[7:1] == SLV_ADDR) begin
                sda_oe <= 1'b1;
                rw     <= shreg[0];
              end else begin
                state <= ST_IGN;
              end
            end
            ST_WR:   sda_oe <= 1'b1;
            default: sda_oe <= 1'b0;
          endcase
        end else if (ack_ph) begin
          ack_ph <= 1'b0;
          bitcnt <= 4'd0;
          case (state)
            ST_ADDR: begin
              if (rw) begin
                state  <= ST_RD;
                shreg  <= rd_byte;
                sda_oe <= ~rd_byte[7];
              end else begin
                state  <= ST_WR;
                sda_oe <= 1'b0;
              end
            end
            ST_WR: begin
              ctrl   <= shreg[2:0];
              sda_oe <= 1'b0;
            end
            default: begin
              if (nack) begin
                state  <= ST_IGN;
                sda_oe <= 1'b0;
              end else begin
                shreg  <= rd_byte;
                sda_oe <= ~rd_byte[7];
              end
            end
          endcase
        end else if (state == ST_RD) begin
          sda_oe <= ~shreg[7];
        end
      end
    end
  end

  assign sda_drive_low = sda_oe;
  assign chan0_en      = (ctrl == 3'b100);
  assign chan1_en      = (ctrl == 3'b101);

endmodule

module i2c_chan_switch_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_sync,
  input logic start_det,
  input logic ignoring,
  input logic sda_drive_low,
  input logic chan0_en,
  input logic chan1_en
);

  assert_sda_moves_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive_low) |-> !scl_sync);

  assert_chan_moves_scl_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({chan1_en, chan0_en}) |-> !scl_sync);

  assert_chan_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(chan0_en && chan1_en));

  assert_ignore_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ignoring |-> !sda_drive_low);

  assert_start_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_drive_low);

endmodule

bind i2c_chan_switch i2c_chan_switch_chk chk_i (
  .clk(clk),
  .rst_n(rst_n),
  .scl_sync(scl_s),
  .start_det(start_det),
  .ignoring(state == ST_IGN),
  .sda_drive_low(sda_drive_low),
  .chan0_en(chan0_en),
  .chan1_en(chan1_en)
);

// File: tb/i2c_chan_switch_tb_top.sv
`timescale 1ns/100ps
module i2c_chan_switch_tb_top;
  localparam int Q = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, m_scl, m_sda;
  logic sda_low, ch0, ch1;
  wire  sda_bus = m_sda & ~sda_low;

  i2c_chan_switch dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
    .sda_drive_low(sda_low), .chan0_en(ch0), .chan1_en(ch1)
  );

  int errors = 0, checks = 0, cyc = 0, hold_until = 0, hold_clk = 2;
  logic [2:0] exp_ctrl = 3'd0;
  bit quiet = 1'b0, done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [1:0] exp_ch();
    return (exp_ctrl == 3'b100) ? 2'b01 : (exp_ctrl == 3'b101) ? 2'b10 : 2'b00;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Reference model comparison on every clock outside settling windows
  always @(negedge clk) begin
    if (rst_n && !done && cyc >= hold_until) begin
      chk({ch1, ch0} == exp_ch(), "R5 per-clock channel", {ch1, ch0}, exp_ch());
      if (quiet) chk(!sda_low, "R3 per-clock release", sda_low, 0);
    end
  end

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input bit b, input bit upd, input logic [2:0] nv, output bit seen);
    m_sda = b;
    w(Q);
    m_scl = 1'b1;
    w(Q/2);
    seen = sda_bus;
    w(Q/2);
    if (upd) begin
      exp_ctrl   = nv;
      hold_until = cyc + 12;
    end
    m_scl = 1'b0;
    w(hold_clk);
  endtask

  task automatic start_c();
    m_sda = 1'b1; w(Q);
    m_scl = 1'b1; w(Q);
    m_sda = 1'b0; w(Q);
    m_scl = 1'b0; w(2);
  endtask

  task automatic stop_c();
    m_sda = 1'b0; w(Q);
    m_scl = 1'b1; w(Q);
    m_sda = 1'b1; w(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input bit upd, input string req);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(b[i], 1'b0, 3'd0, s);
      chk(s == b[i], "R4 no pull during write bits", s, b[i]);
    end
    clk_bit(1'b1, upd, b[2:0], s);
    chk(s == !exp_ack, req, s, !exp_ack);
  endtask

  task automatic recv_byte(input logic [7:0] e, input bit mack, input string req);
    bit s;
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, 1'b0, 3'd0, s);
      got[i] = s;
    end
    chk(got == e, req, got, e);
    clk_bit(!mack, 1'b0, 3'd0, s);
  endtask

  task automatic chk_ch(input logic [1:0] e, input string req);
    w(12);
    chk({ch1, ch0} == e, req, {ch1, ch0}, e);
  endtask

  initial begin
    bit s;
    m_scl = 1'b1; m_sda = 1'b1; rst_n = 1'b0;
    w(5);
    chk({ch1, ch0, sda_low} == 3'b000, "R1 during reset", {ch1, ch0, sda_low}, 0);
    rst_n = 1'b1;
    w(5);
    chk({ch1, ch0, sda_low} == 3'b000, "R1 after reset", {ch1, ch0, sda_low}, 0);

    // R2, R4, R6: write selecting channel 0, checked before STOP
    start_c();
    send_byte(8'hE0, 1'b1, 1'b0, "R2 write address ack");
    send_byte(8'h04, 1'b1, 1'b1, "R4 data ack");
    chk_ch(2'b01, "R6 channel 0 before stop");
    stop_c();

    // R4, R5: upper bits ignored, channel 1
    start_c();
    send_byte(8'hE0, 1'b1, 1'b0, "R2 write address ack");
    send_byte(8'hFD, 1'b1, 1'b1, "R4 data ack upper bits set");
    chk_ch(2'b10, "R5 channel 1 from 101");
    stop_c();

    // R8, R9: read, repeat on master ack, release on nack
    start_c();
    send_byte(8'hE1, 1'b1, 1'b0, "R2 read address ack");
    recv_byte(8'h05, 1'b1, "R8 read byte");
    recv_byte(8'h05, 1'b0, "R9 repeated byte after master ack");
    clk_bit(1'b1, 1'b0, 3'd0, s);
    chk(s == 1'b1, "R9 released after nack", s, 1);
    stop_c();

    // R7: several writes in one transaction
    start_c();
    send_byte(8'hE0, 1'b1, 1'b0, "R2 write address ack");
    send_byte(8'h05, 1'b1, 1'b1, "R7 first byte ack");
    chk_ch(2'b10, "R7 first byte");
    send_byte(8'h04, 1'b1, 1'b1, "R7 second byte ack");
    chk_ch(2'b01, "R7 second byte");
    send_byte(8'h07, 1'b1, 1'b1, "R7 third byte ack");
    chk_ch(2'b00, "R5 value 111 disconnects");
    stop_c();

    // R3: mismatched address, following byte ignored
    start_c();
    quiet = 1'b1;
    send_byte(8'hE2, 1'b0, 1'b0, "R3 no ack on mismatch");
    send_byte(8'h04, 1'b0, 1'b0, "R3 no ack while ignoring");
    chk_ch(2'b00, "R3 channel unchanged");
    stop_c();
    quiet = 1'b0;

    // R10: repeated START from write into read, and after a mismatch
    start_c();
    send_byte(8'hE0, 1'b1, 1'b0, "R2 write address ack");
    send_byte(8'h05, 1'b1, 1'b1, "R7 data ack");
    start_c();
    send_byte(8'hE1, 1'b1, 1'b0, "R10 address ack after repeated start");
    recv_byte(8'h05, 1'b0, "R10 read after repeated start");
    stop_c();
    start_c();
    send_byte(8'hE2, 1'b0, 1'b0, "R3 no ack on mismatch");
    start_c();
    send_byte(8'hE0, 1'b1, 1'b0, "R10 ack after restart from mismatch");
    send_byte(8'h00, 1'b1, 1'b1, "R4 data ack");
    chk_ch(2'b00, "R5 B2 clear disconnects");
    stop_c();

    // R11: SDA changes in the same clock as SCL falls
    hold_clk = 0;
    start_c();
    send_byte(8'hE0, 1'b1, 1'b0, "R11 address ack zero hold");
    send_byte(8'h0C, 1'b1, 1'b1, "R11 data ack zero hold");
    chk_ch(2'b01, "R11 channel 0 zero hold");
    send_byte(8'hF3, 1'b1, 1'b1, "R11 second data ack zero hold");
    chk_ch(2'b00, "R11 disconnect zero hold");
    stop_c();
    start_c();
    send_byte(8'hE1, 1'b1, 1'b0, "R11 read address ack zero hold");
    recv_byte(8'h03, 1'b0, "R8 read byte zero hold");
    stop_c();
    hold_clk = 2;

    w(10);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule